// File: doc/BRIEF.md
# Peripheral Interrupt Register Logic

This block holds the software-visible interrupt registers of one peripheral. Every interrupt source of the peripheral presents an active-high event line. A rising event is captured in a sticky status bit that stays set until software acknowledges it. A mask bit per source decides whether the captured status reaches the processor. The processor sees the result as an active-high level on a dedicated output wire. Software can also raise any status bit by writing to an injection register, which lets handlers be tested without provoking the real condition.

Software reaches the block through a plain register port. The port has a byte address, a write strobe, 32 bits of write data and 32 bits of read data. Writes take effect at the rising clock edge. Reads are combinational from the presented address. The two lowest address bits are ignored, so every access covers the whole 32-bit word. The number of sources is a parameter. A count of zero, or a count above 32, stops elaboration with an error.

There is no sequencer. Each source is a small two-state machine, IDLE (status clear) and PENDING (status set). The transition SET moves IDLE to PENDING on an event or an injection. The transition ACK moves PENDING to IDLE when software writes 1 with no new event present.

Top module: `irq_reg_block`

## Requirements
- R1: While the active-low asynchronous reset is low, every status bit, every mask bit and every interrupt output is 0. Reads of the status and mask words then return 0.
- R2: An event that is high at a rising clock edge sets its status bit at that edge. Hardware never clears a status bit.
- R3: A write of 1 to a status bit, at word offset 0x0, clears it. A write of 0 to a status bit leaves it unchanged.
- R4: If an event is high in the same cycle that software clears its status bit, the bit stays set.
- R5: A write of 1 to a bit of the injection word, at word offset 0x8, sets the matching status bit. The injection word always reads as 0. It changes no mask bit.
- R6: A read at word offset 0x0 returns the raw status bits in bits [N-1:0], whatever the mask holds.
- R7: Interrupt output i is high exactly when status bit i and mask bit i are both 1. It follows the registered status with no added cycle.
- R8: The mask word, at word offset 0x4, is read/write. It changes only on a write to that offset. Read bits at and above N return 0.
- R9: Address bits [1:0] are ignored. Any word offset other than 0x0, 0x4 and 0x8 reads as 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | NUM_IRQ | Active-high event per interrupt source |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_we_i | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the presented address |
| irq_o | output | NUM_IRQ | Masked active-high interrupt levels |

## Verification
The assertions assume that event lines, address, write strobe and write data are synchronous to the clock. They also assume these inputs are free of unknowns at every rising edge after reset. A write therefore lasts exactly the cycles in which the strobe is sampled high. The stimulus changes every input on the falling edge. It holds the write strobe high for a single edge per access. It returns the address to the status word before reading the results, so each check sees settled registered state.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

    localparam int unsigned REG_W = 32;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_INJECT = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wr_status;
        logic wr_mask;
        logic wr_inject;
    } wr_strobe_t;

    typedef enum logic {
        SRC_IDLE    = 1'b0,
        SRC_PENDING = 1'b1
    } src_state_e;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_regs_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic [IDX_W-1:0] word_idx_i,
    input  logic             we_i,
    output reg_sel_e         sel_o,
    output wr_strobe_t       wr_o
);

    always_comb begin
        if (word_idx_i == IDX_W'(0)) begin
            sel_o = SEL_STATUS;
        end else if (word_idx_i == IDX_W'(1)) begin
            sel_o = SEL_MASK;
        end else if (word_idx_i == IDX_W'(2)) begin
            sel_o = SEL_INJECT;
        end else begin
            sel_o = SEL_NONE;
        end
    end

    always_comb begin
        wr_o = '0;
        unique case (sel_o)
            SEL_STATUS: wr_o.wr_status = we_i;
            SEL_MASK:   wr_o.wr_mask   = we_i;
            SEL_INJECT: wr_o.wr_inject = we_i;
            SEL_NONE:   wr_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_regs_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic event_i,
    input  logic inject_i,
    input  logic ack_i,
    input  logic mask_we_i,
    input  logic mask_d_i,
    output logic status_o,
    output logic mask_o,
    output logic irq_o
);

    src_state_e state_q, state_d;
    logic       mask_q;
    logic       set_req;

    assign set_req = event_i | inject_i;

    // SET wins over ACK when both arrive in one cycle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE:    if (set_req) state_d = SRC_PENDING;
            SRC_PENDING: if (ack_i && !set_req) state_d = SRC_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SRC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= 1'b0;
        end else if (mask_we_i) begin
            mask_q <= mask_d_i;
        end
    end

    always_comb begin
        status_o = (state_q == SRC_PENDING);
        mask_o   = mask_q;
        irq_o    = status_o & mask_q;
    end

    p_event_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_i |=> status_o);

    p_hw_never_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o && !ack_i) |=> status_o);

    p_ack_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !event_i && !inject_i) |=> !status_o);

    p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && event_i) |=> status_o);

    p_inject_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inject_i |=> status_o);

    p_mask_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mask_we_i |=> $stable(mask_o));

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_regs_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 8
) (
    input  reg_sel_e           sel_i,
    input  logic [NUM_IRQ-1:0] status_i,
    input  logic [NUM_IRQ-1:0] mask_i,
    output logic [REG_W-1:0]   rdata_o
);

    always_comb begin
        rdata_o = '0;
        unique case (sel_i)
            SEL_STATUS: rdata_o[NUM_IRQ-1:0] = status_i;
            SEL_MASK:   rdata_o[NUM_IRQ-1:0] = mask_i;
            SEL_INJECT: rdata_o = '0;
            SEL_NONE:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_reg_block.sv
module irq_reg_block
    import irq_regs_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 8,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IRQ-1:0] event_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_we_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic [NUM_IRQ-1:0] irq_o
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    if (NUM_IRQ < 1 || NUM_IRQ > REG_W) begin : g_bad_irq_count
        $fatal(1, "irq_reg_block: NUM_IRQ must lie in 1..32");
    end
    if (ADDR_W < 4) begin : g_bad_addr_width
        $fatal(1, "irq_reg_block: ADDR_W must be at least 4");
    end

    reg_sel_e           sel;
    wr_strobe_t         wr;
    logic [NUM_IRQ-1:0] status;
    logic [NUM_IRQ-1:0] mask;
    logic               unused_bits;

    // Byte lanes are not decoded; every access is a full word.
    assign unused_bits = ^{reg_addr_i[1:0], reg_wdata_i};

    irq_addr_decode #(
        .IDX_W(IDX_W)
    ) u_decode (
        .word_idx_i(reg_addr_i[ADDR_W-1:2]),
        .we_i      (reg_we_i),
        .sel_o     (sel),
        .wr_o      (wr)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        irq_src_cell u_cell (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .event_i  (event_i[i]),
            .inject_i (wr.wr_inject & reg_wdata_i[i]),
            .ack_i    (wr.wr_status & reg_wdata_i[i]),
            .mask_we_i(wr.wr_mask),
            .mask_d_i (reg_wdata_i[i]),
            .status_o (status[i]),
            .mask_o   (mask[i]),
            .irq_o    (irq_o[i])
        );
    end

    irq_read_mux #(
        .NUM_IRQ(NUM_IRQ)
    ) u_rmux (
        .sel_i   (sel),
        .status_i(status),
        .mask_i  (mask),
        .rdata_o (reg_rdata_o)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            p_reset_quiet_r1: assert (irq_o == '0 && status == '0 && mask == '0);
        end
    end

    p_inject_reads_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel == SEL_INJECT) |-> (reg_rdata_o == '0));

    p_irq_within_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel == SEL_STATUS) |-> ((irq_o & ~reg_rdata_o[NUM_IRQ-1:0]) == '0));

    p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel == SEL_NONE) |-> (reg_rdata_o == '0));

endmodule

// File: tb/irq_reg_block_bench.sv
module irq_reg_block_bench;

    localparam int NIRQ = 8;
    localparam int AW   = 6;
    localparam int NVEC = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIRQ-1:0] ev = '0;
    logic [AW-1:0]   addr = '0;
    logic            we = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NIRQ-1:0] irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_reg_block #(.NUM_IRQ(NIRQ), .ADDR_W(AW)) u_irq_reg_block (
        .clk_i(clk), .rst_ni(rst_n), .event_i(ev), .reg_addr_i(addr),
        .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    // {event, we, addr, wdata, expected status, expected irq}
    localparam logic [62:0] VEC [NVEC] = '{
        {8'h05, 1'b0, 6'h00, 32'h0000_0000, 8'h05, 8'h00}, // R2 event latch, mask off
        {8'h00, 1'b1, 6'h04, 32'h0000_00FF, 8'h05, 8'h05}, // R7 unmask all
        {8'h00, 1'b1, 6'h00, 32'h0000_0001, 8'h04, 8'h04}, // R3 clear bit0
        {8'h00, 1'b1, 6'h00, 32'h0000_0000, 8'h04, 8'h04}, // R3 zero write
        {8'h02, 1'b1, 6'h00, 32'h0000_0002, 8'h06, 8'h06}, // R4 set wins
        {8'h00, 1'b1, 6'h08, 32'h0000_0080, 8'h86, 8'h86}, // R5 inject bit7
        {8'h00, 1'b1, 6'h04, 32'h0000_000F, 8'h86, 8'h06}, // R6 raw status, R7 mask
        {8'h00, 1'b1, 6'h00, 32'h0000_00FF, 8'h00, 8'h00}, // R3 clear all
        {8'h00, 1'b1, 6'h0C, 32'hFFFF_FFFF, 8'h00, 8'h00}, // R9 unmapped write
        {8'h30, 1'b0, 6'h00, 32'h0000_0000, 8'h30, 8'h00}, // R6 masked pending
        {8'h00, 1'b1, 6'h05, 32'hFFFF_FFFF, 8'h30, 8'h30}, // R9 byte offset ignored
        {8'h10, 1'b1, 6'h00, 32'h0000_0030, 8'h10, 8'h10}  // R4 event held on clear
    };

    function automatic string vec_req(input int k);
        case (k)
            0: return "R2";
            1, 6: return "R7";
            2, 3, 7: return "R3";
            4, 11: return "R4";
            5: return "R5";
            9: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic [NIRQ-1:0] e, input logic w,
                          input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        ev = e; we = w; addr = a; wdata = d;
        @(negedge clk);
        ev = '0; we = 1'b0; addr = '0; wdata = '0;
        #1;
    endtask

    task automatic read_at(input logic [AW-1:0] a);
        addr = a;
        #1;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        ev = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1", {24'h0, irq}, 32'h0);
        read_at(6'h00); check("R1", rdata, 32'h0);
        read_at(6'h04); check("R1", rdata, 32'h0);
        ev = '0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            logic [62:0] v;
            v = VEC[k];
            access(v[62:55], v[54], v[53:48], v[47:16]);
            read_at(6'h00);
            check(vec_req(k), rdata, {24'h0, v[15:8]});
            check(vec_req(k), {24'h0, irq}, {24'h0, v[7:0]});
        end

        // R8: mask reads back, upper bits zero
        read_at(6'h04); check("R8", rdata, 32'h0000_00FF);
        // R5: injection word reads zero
        read_at(6'h08); check("R5", rdata, 32'h0);
        // R9: unmapped read zero
        read_at(6'h3C); check("R9", rdata, 32'h0);
        // R9: unmapped write leaves mask intact
        access('0, 1'b1, 6'h10, 32'h0);
        read_at(6'h04); check("R9", rdata, 32'h0000_00FF);
        // R5: injection leaves mask intact
        access('0, 1'b1, 6'h08, 32'h0000_0001);
        read_at(6'h04); check("R5", rdata, 32'h0000_00FF);
        read_at(6'h00); check("R5", rdata, 32'h0000_0011);
        // R2: state persists many cycles with no event
        repeat (20) @(negedge clk);
        read_at(6'h00); check("R2", rdata, 32'h0000_0011);
        check("R7", {24'h0, irq}, 32'h0000_0011);
        // R1: mid-run reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", {24'h0, irq}, 32'h0);
        read_at(6'h04); check("R1", rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule